// File: doc/BRIEF.md
# Ternary Residue Modular Adder

This block adds two residues of a residue-number channel whose modulus is 3^n, 3^n-1 or 3^n-2, with the modulus fixed at elaboration by a parameter. Operands and the result are n balanced-free ternary digits (trits). Each trit is carried on two binary wires. The arithmetic is done by a chain of radix-3 full-adder cells. The carry between neighbouring cells takes the value 0, 1 or 2.

The two moduli below 3^n are reduced by carry-select. A second digit chain adds the same operands with the modulus complement (1 or 2) injected as the ternary carry-in of its lowest cell. When that chain produces a nonzero carry out of its top trit, the uncorrected sum was at least m, and its n-digit sum is already the reduced result. For the 3^n modulus the single chain's top carry is simply dropped. An optional output register adds one cycle of latency and holds its value while no new operand pair is presented. The reset input is asynchronous and active low, and it is expected to be deasserted synchronously to `clk` upstream.

Top module: `tern_mod_adder`

## Requirements
- R1: Each trit is encoded 2'b00 = 0, 2'b01 = 1, 2'b10 = 2, and 2'b11 is illegal. Trit i occupies bits [2i+1:2i], with trit 0 the least significant. Operands presented with `valid_in` high contain only legal trits.
- R2: With MODSEL = 0 (modulus 3^n), the result is (A + B) mod 3^n, which is the n-trit sum with the top carry discarded.
- R3: With MODSEL = 1 (modulus 3^n-1), the result is A + B when A + B < m, and A + B - m otherwise.
- R4: With MODSEL = 2 (modulus 3^n-2), the result is A + B when A + B < m, and A + B - m otherwise.
- R5: For operands in the range 0..m-1, the result consists of legal trits and is below m, including the case A = B = m-1.
- R6: With REGISTERED = 1, `valid_out` equals the `valid_in` of the previous cycle, and `sum_out` shows the result of the operands accepted in that cycle.
- R7: With REGISTERED = 1, a cycle with `valid_in` low leaves `sum_out` unchanged, whatever the operands are in that cycle.
- R8: With REGISTERED = 1, reset asserted drives `valid_out` to 0 and `sum_out` to all zeros without waiting for a clock edge.
- R9: With REGISTERED = 0, `valid_out` follows `valid_in` and `sum_out` shows the reduced sum of the present operands in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_in | input | 1 | Operand pair is present |
| a_in | input | 2*N_TRITS | First residue, n trits |
| b_in | input | 2*N_TRITS | Second residue, n trits |
| valid_out | output | 1 | Result is present |
| sum_out | output | 2*N_TRITS | Reduced sum, n trits |

## Verification
With three trits, the bench applies every operand pair from 0..26 to instances for all three moduli. Each instance accepts only the pairs inside its own range. Pairs whose sum stays below m show whether the plain chain is chosen. Pairs at or above m, up to (m-1)+(m-1), show that the select comes from the corrected chain's carry and that the injected complement of 1 or 2 is right. For 3^n, pairs that overflow show that the top carry is dropped. Dropping `valid_in` while the operands change separates holding the register from loading it. A combinational instance compares its same-cycle result with that of the registered one, and a reset mid-run shows that the clear is asynchronous.

// File: rtl/tern_pkg.sv
package tern_pkg;
  typedef logic [1:0] trit_t;

  localparam trit_t T0 = 2'b00;
  localparam trit_t T1 = 2'b01;
  localparam trit_t T2 = 2'b10;

  function automatic int unsigned pow3(input int unsigned n);
    int unsigned p;
    p = 1;
    for (int unsigned i = 0; i < n; i++) p = p * 3;
    return p;
  endfunction
endpackage

// File: rtl/tern_fa.sv
module tern_fa
  import tern_pkg::*;
(
  input  trit_t a,
  input  trit_t b,
  input  trit_t cin,
  output trit_t s,
  output trit_t cout
);
  logic [3:0] tot;

  always_comb begin
    tot = {2'b00, a} + {2'b00, b} + {2'b00, cin};
    if (tot >= 4'd6) begin
      cout = T2;
      s    = trit_t'(tot - 4'd6);
    end else if (tot >= 4'd3) begin
      cout = T1;
      s    = trit_t'(tot - 4'd3);
    end else begin
      cout = T0;
      s    = trit_t'(tot);
    end
  end
endmodule

// File: rtl/tern_ripple.sv
module tern_ripple
  import tern_pkg::*;
#(
  parameter int N_TRITS = 3
) (
  input  logic [2*N_TRITS-1:0] a,
  input  logic [2*N_TRITS-1:0] b,
  input  trit_t                cin,
  output logic [2*N_TRITS-1:0] s,
  output trit_t                cout
);
  localparam int CW = 2 * (N_TRITS + 1);

  logic [CW-1:0] carry;

  assign carry[1:0] = cin;

  for (genvar gi = 0; gi < N_TRITS; gi++) begin : g_cell
    tern_fa u_cell (
      .a    (a[2*gi +: 2]),
      .b    (b[2*gi +: 2]),
      .cin  (carry[2*gi +: 2]),
      .s    (s[2*gi +: 2]),
      .cout (carry[2*gi+2 +: 2])
    );
  end

  assign cout = carry[2*N_TRITS +: 2];
endmodule

// File: rtl/tern_out_stage.sv
module tern_out_stage #(
  parameter int W          = 6,
  parameter bit REGISTERED = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         vin,
  input  logic [W-1:0] din,
  output logic         vout,
  output logic [W-1:0] dout
);
  if (REGISTERED) begin : g_reg
    logic [W-1:0] q;
    logic [W-1:0] q_nxt;
    logic         v_q;

    always_comb begin
      q_nxt = vin ? din : q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q   <= '0;
        v_q <= 1'b0;
      end else begin
        v_q <= vin;
        q   <= q_nxt;
      end
    end

    assign vout = v_q;
    assign dout = q;
  end else begin : g_comb
    logic clk_rst_unused;
    assign clk_rst_unused = clk ^ rst_n;
    assign vout = vin;
    assign dout = din;
  end
endmodule

// File: rtl/tern_mod_adder.sv
module tern_mod_adder
  import tern_pkg::*;
#(
  parameter int N_TRITS    = 3,
  parameter int MODSEL     = 2,
  parameter bit REGISTERED = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 valid_in,
  input  logic [2*N_TRITS-1:0] a_in,
  input  logic [2*N_TRITS-1:0] b_in,
  output logic                 valid_out,
  output logic [2*N_TRITS-1:0] sum_out
);
  localparam int    W    = 2 * N_TRITS;
  localparam trit_t COMP = trit_t'(MODSEL);

  logic [W-1:0] raw_sum;
  logic [W-1:0] sum_nxt;
  trit_t        raw_cout_unused;

  // plain chain: A + B with carry-in 0
  tern_ripple #(.N_TRITS(N_TRITS)) u_raw (
    .a    (a_in),
    .b    (b_in),
    .cin  (T0),
    .s    (raw_sum),
    .cout (raw_cout_unused)
  );

  if (MODSEL == 0) begin : g_pow
    // modulus 3^n: top carry is a multiple of the modulus
    assign sum_nxt = raw_sum;
  end else begin : g_csel
    logic [W-1:0] corr_sum;
    trit_t        corr_cout;
    logic         wrap;

    // corrected chain: A + B + complement through the ternary carry-in
    tern_ripple #(.N_TRITS(N_TRITS)) u_corr (
      .a    (a_in),
      .b    (b_in),
      .cin  (COMP),
      .s    (corr_sum),
      .cout (corr_cout)
    );

    // A + B + comp >= 3^n exactly when A + B >= m
    assign wrap    = (corr_cout != T0);
    assign sum_nxt = wrap ? corr_sum : raw_sum;
  end

  tern_out_stage #(.W(W), .REGISTERED(REGISTERED)) u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .vin   (valid_in),
    .din   (sum_nxt),
    .vout  (valid_out),
    .dout  (sum_out)
  );
endmodule

// File: rtl/tern_mod_adder_chk.sv
module tern_mod_adder_chk
  import tern_pkg::*;
#(
  parameter int N_TRITS    = 3,
  parameter int MODSEL     = 2,
  parameter bit REGISTERED = 1'b1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 valid_in,
  input logic [2*N_TRITS-1:0] a_in,
  input logic [2*N_TRITS-1:0] b_in,
  input logic                 valid_out,
  input logic [2*N_TRITS-1:0] sum_out
);
  localparam int unsigned MODV = pow3(N_TRITS) - MODSEL;

  function automatic bit legal(input logic [2*N_TRITS-1:0] v);
    bit ok;
    ok = 1'b1;
    for (int i = 0; i < N_TRITS; i++)
      if (v[2*i +: 2] == 2'b11) ok = 1'b0;
    return ok;
  endfunction

  function automatic int unsigned value(input logic [2*N_TRITS-1:0] v);
    int unsigned acc;
    acc = 0;
    for (int i = N_TRITS - 1; i >= 0; i--) acc = acc * 3 + int'(v[2*i +: 2]);
    return acc;
  endfunction

  logic [31:0] model_sum;
  assign model_sum = (value(a_in) + value(b_in)) % MODV;

  // R1
  a_r1_legal_operands: assert property (@(posedge clk) disable iff (!rst_n)
    valid_in |-> (legal(a_in) && legal(b_in)));

  // R5
  a_r5_operand_range: assert property (@(posedge clk) disable iff (!rst_n)
    valid_in |-> (value(a_in) < MODV && value(b_in) < MODV));

  a_r5_result_range: assert property (@(posedge clk) disable iff (!rst_n)
    valid_out |-> (legal(sum_out) && value(sum_out) < MODV));

  if (REGISTERED) begin : g_reg
    a_r6_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
      valid_in |=> valid_out);
    a_r6_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_in |=> !valid_out);
    // covers R2, R3, R4 depending on MODSEL
    a_r3_mod_sum: assert property (@(posedge clk) disable iff (!rst_n)
      valid_in |=> (32'(value(sum_out)) == $past(model_sum)));
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_in |=> $stable(sum_out));
  end else begin : g_comb
    a_r9_valid_pass: assert property (@(posedge clk) disable iff (!rst_n)
      valid_out == valid_in);
    a_r9_same_cycle_sum: assert property (@(posedge clk) disable iff (!rst_n)
      valid_in |-> (32'(value(sum_out)) == model_sum));
  end
endmodule

bind tern_mod_adder tern_mod_adder_chk #(
  .N_TRITS(N_TRITS), .MODSEL(MODSEL), .REGISTERED(REGISTERED)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .valid_in  (valid_in),
  .a_in      (a_in),
  .b_in      (b_in),
  .valid_out (valid_out),
  .sum_out   (sum_out)
);

// File: tb/tern_mod_adder_bench.sv
`timescale 1ns/1ps
module tern_mod_adder_bench;
  localparam int N = 3;
  localparam int W = 2 * N;

  logic clk = 1'b0;
  logic rst_n;
  logic [W-1:0] a, b;
  logic v0, v1, v2;
  logic vo0, vo1, vo2, voc;
  logic [W-1:0] s0, s1, s2, sc;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tern_mod_adder #(.N_TRITS(N), .MODSEL(0), .REGISTERED(1'b1)) u_tern_mod_adder_m0 (
    .clk(clk), .rst_n(rst_n), .valid_in(v0), .a_in(a), .b_in(b),
    .valid_out(vo0), .sum_out(s0));
  tern_mod_adder #(.N_TRITS(N), .MODSEL(1), .REGISTERED(1'b1)) u_tern_mod_adder_m1 (
    .clk(clk), .rst_n(rst_n), .valid_in(v1), .a_in(a), .b_in(b),
    .valid_out(vo1), .sum_out(s1));
  tern_mod_adder #(.N_TRITS(N), .MODSEL(2), .REGISTERED(1'b1)) u_tern_mod_adder (
    .clk(clk), .rst_n(rst_n), .valid_in(v2), .a_in(a), .b_in(b),
    .valid_out(vo2), .sum_out(s2));
  tern_mod_adder #(.N_TRITS(N), .MODSEL(1), .REGISTERED(1'b0)) u_tern_mod_adder_c1 (
    .clk(clk), .rst_n(rst_n), .valid_in(v1), .a_in(a), .b_in(b),
    .valid_out(voc), .sum_out(sc));

  // R1 encoding: 00=0, 01=1, 10=2, trit 0 at bits [1:0]
  function automatic logic [W-1:0] enc(input int x);
    logic [W-1:0] v;
    int r;
    r = x;
    for (int i = 0; i < N; i++) begin
      v[2*i +: 2] = 2'(r % 3);
      r = r / 3;
    end
    return v;
  endfunction

  function automatic int dec(input logic [W-1:0] v);
    int acc;
    acc = 0;
    for (int i = N - 1; i >= 0; i--) acc = acc * 3 + int'(v[2*i +: 2]);
    return acc;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  initial begin
    int e, hold0, hold1, hold2;
    rst_n = 1'b0;
    a = '0; b = '0;
    v0 = 1'b0; v1 = 1'b0; v2 = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R8 reset state
    chk(vo0 == 1'b0 && vo1 == 1'b0 && vo2 == 1'b0, "R8 valid_out in reset", int'(vo0|vo1|vo2), 0);
    chk(s0 == '0 && s1 == '0 && s2 == '0, "R8 sum_out in reset", dec(s0|s1|s2), 0);
    rst_n = 1'b1;

    for (int x = 0; x < 27; x++) begin
      for (int y = 0; y < 27; y++) begin
        @(negedge clk);
        a  = enc(x);
        b  = enc(y);
        v0 = 1'b1;
        v1 = (x < 26) && (y < 26);
        v2 = (x < 25) && (y < 25);
        @(posedge clk);
        @(negedge clk);
        // R2: modulus 27, carry discarded
        e = (x + y) % 27;
        chk(vo0 == 1'b1, "R6 valid_out mod27", int'(vo0), 1);
        chk(dec(s0) == e, "R2 sum mod27", dec(s0), e);
        if (v1) begin
          e = (x + y >= 26) ? x + y - 26 : x + y;
          chk(vo1 == 1'b1, "R6 valid_out mod26", int'(vo1), 1);
          chk(dec(s1) == e, "R3 sum mod26", dec(s1), e);
          chk(dec(s1) < 26, "R5 range mod26", dec(s1), 25);
          chk(voc == 1'b1 && dec(sc) == e, "R9 comb sum mod26", dec(sc), e);
        end else begin
          chk(vo1 == 1'b0, "R6 idle valid_out mod26", int'(vo1), 0);
        end
        if (v2) begin
          e = (x + y >= 25) ? x + y - 25 : x + y;
          chk(vo2 == 1'b1, "R6 valid_out mod25", int'(vo2), 1);
          chk(dec(s2) == e, "R4 sum mod25", dec(s2), e);
          chk(dec(s2) < 25, "R5 range mod25", dec(s2), 24);
        end
      end
    end

    // R7: operands change with valid low, outputs must hold
    @(negedge clk);
    hold0 = dec(s0); hold1 = dec(s1); hold2 = dec(s2);
    v0 = 1'b0; v1 = 1'b0; v2 = 1'b0;
    a = enc(7); b = enc(5);
    @(posedge clk);
    @(negedge clk);
    chk(dec(s0) == hold0, "R7 hold mod27", dec(s0), hold0);
    chk(dec(s1) == hold1, "R7 hold mod26", dec(s1), hold1);
    chk(dec(s2) == hold2, "R7 hold mod25", dec(s2), hold2);
    chk(vo0 == 1'b0 && vo2 == 1'b0, "R6 valid_out low", int'(vo0|vo2), 0);
    chk(voc == 1'b0 && dec(sc) == 12, "R9 comb follows operands", dec(sc), 12);

    // R8: asynchronous clear mid-run
    @(negedge clk);
    v2 = 1'b1; a = enc(24); b = enc(24);
    @(posedge clk);
    @(negedge clk);
    chk(dec(s2) == 23, "R4 top pair mod25", dec(s2), 23);
    #1 rst_n = 1'b0;
    #0.5;
    chk(vo2 == 1'b0 && s2 == '0, "R8 async clear", dec(s2), 0);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
      $finish;
    end
  end
endmodule